// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, on every clock, which one of the resident warps may issue its next instruction. A pool of warp slots holds the warps of the thread blocks that have been admitted. A new block comes with a thread count. The block splits it into 32-lane warps and admits the whole block only when enough slots are free at the same moment. Each admitted warp is then scheduled on its own.

A warp can be picked only while it is resident, its next instruction is valid and the source operands of that instruction are ready. The pick goes to the oldest eligible warp. Age counts how many blocks were admitted after the warp's own block. Warps of equal age take turns in round-robin order. The choice is combinational within the cycle, so moving from one warp to another costs no cycles. When a warp signals completion its slot is returned to the pool, and a later block can use it.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is applied, and until the synchronised reset is released, launch_accept and issue_valid stay low and every slot is free.
- R2: A launch request needs ceil(threads/32) warp slots. When it is accepted, launch_accept is high in the same cycle and launch_slots (bit i = slot i) marks the lowest-numbered free slots, exactly that many of them.
- R3: A launch that needs more slots than are currently free is refused: launch_accept stays low and no slot changes state.
- R4: A thread count of zero, or one that needs more warps than the pool holds, is always refused.
- R5: A warp is eligible only when its slot is resident and both its operand-ready bit and its instruction-valid bit are high. Only an eligible warp is issued.
- R6: At most one warp issues per cycle. When no warp is eligible, issue_valid is low.
- R7: Among eligible warps the one with the greatest age issues. Age is the number of block admissions since the warp's own admission, saturating at 2^AGE_W-1.
- R8: Among eligible warps of equal greatest age, the search starts at the slot after the most recently issued one and wraps around. After reset the search starts at slot 0.
- R9: A warp_done pulse on a resident slot frees it from the next cycle on, and a later launch may then reuse that slot.
- R10: Issue is decided combinationally in the cycle the inputs present, so consecutive cycles may issue different warps with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| launch_valid | input | 1 | A thread block asks for admission this cycle |
| launch_threads | input | THR_W | Thread count of the requesting block |
| launch_accept | output | 1 | The block is admitted this cycle |
| launch_slots | output | NUM_WARPS | Slots given to the admitted block |
| warp_op_ready | input | NUM_WARPS | Per slot: operands of the next instruction are ready |
| warp_instr_valid | input | NUM_WARPS | Per slot: a next instruction is present |
| warp_done | input | NUM_WARPS | Per slot: the warp has finished, so its slot is freed |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | WID_W | Slot index of the issuing warp |

## Verification
On every cycle the assertions check four things. The issued warp must be eligible. No eligible warp may be older than the one issued. An allocation may only use free slots, and it must use exactly the required number of them. A completing warp must release its slot. The bench scenarios are needed for the rest: the exact slot mask of each admission, refusal when free slots are scattered, and the round-robin order among warps of equal age, which depends on the issue history. They also show that freed slots are taken again by a later block, and that different warps issue back to back.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int LANES_PER_WARP = 32;

  function automatic int thr_bits(input int slots);
    return $clog2(slots * LANES_PER_WARP + 1);
  endfunction
endpackage

// File: rtl/warp_slot_pool.sv
module warp_slot_pool #(
  parameter int NUM_WARPS = 8,
  parameter int AGE_W     = 3,
  parameter int THR_W     = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            launch_valid,
  input  logic [THR_W-1:0]                launch_threads,
  input  logic [NUM_WARPS-1:0]            warp_done,
  output logic                            launch_accept,
  output logic [NUM_WARPS-1:0]            launch_slots,
  output logic [NUM_WARPS-1:0]            resident,
  output logic [NUM_WARPS-1:0][AGE_W-1:0] warp_age
);
  import warp_sched_pkg::*;
  localparam int NW = THR_W + 1;

  logic [NUM_WARPS-1:0]            busy_q, busy_d;
  logic [NUM_WARPS-1:0][AGE_W-1:0] age_q, age_d;
  logic [NW-1:0] need, free_cnt, taken;
  logic          need_ok, fits, state_en;
  logic [NUM_WARPS-1:0] alloc;

  always_comb begin
    need     = ({1'b0, launch_threads} + NW'(LANES_PER_WARP - 1)) / NW'(LANES_PER_WARP);
    need_ok  = (launch_threads != '0) && (need <= NW'(NUM_WARPS));
    free_cnt = NW'($countones(~busy_q));
    fits     = need_ok && (free_cnt >= need);
    launch_accept = launch_valid && fits && rst_n;
    alloc = '0;
    taken = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (!busy_q[i] && (taken < need)) begin
        alloc[i] = 1'b1;
        taken    = taken + NW'(1);
      end
    end
    launch_slots = launch_accept ? alloc : '0;
  end

  always_comb begin
    busy_d   = (busy_q & ~warp_done) | launch_slots;
    age_d    = age_q;
    state_en = launch_accept || (|(warp_done & busy_q));
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (launch_slots[i]) begin
        age_d[i] = '0;
      end else if (launch_accept && busy_q[i] && (age_q[i] != '1)) begin
        age_d[i] = age_q[i] + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      age_q  <= '0;
    end else if (state_en) begin
      busy_q <= busy_d;
      age_q  <= age_d;
    end
  end

  assign resident = busy_q;
  assign warp_age = age_q;

  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_accept |-> ((launch_slots & resident) == '0));
  assert_alloc_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_accept |-> ($countones(launch_slots) == int'(need)));
  assert_zero_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_threads == '0) |-> !launch_accept);

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_free_chk
    assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (warp_done[g] && resident[g]) |=> !resident[g]);
  end
endmodule

// File: rtl/warp_issue_pick.sv
module warp_issue_pick #(
  parameter int NUM_WARPS = 8,
  parameter int AGE_W     = 3,
  parameter int WID_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WARPS-1:0]            eligible,
  input  logic [NUM_WARPS-1:0][AGE_W-1:0] warp_age,
  output logic                            issue_valid,
  output logic [WID_W-1:0]                issue_warp
);
  logic [WID_W-1:0]     last_q, last_d;
  logic [AGE_W-1:0]     top_age;
  logic [NUM_WARPS-1:0] cand;
  logic                 found;
  logic [WID_W-1:0]     pick;

  always_comb begin
    top_age = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (eligible[i] && (warp_age[i] > top_age)) top_age = warp_age[i];
    end
    for (int i = 0; i < NUM_WARPS; i++) begin
      cand[i] = eligible[i] && (warp_age[i] == top_age);
    end
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      if (!found && cand[(int'(last_q) + k) % NUM_WARPS]) begin
        found = 1'b1;
        pick  = WID_W'((int'(last_q) + k) % NUM_WARPS);
      end
    end
    issue_valid = found;
    issue_warp  = pick;
    last_d      = found ? pick : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= WID_W'(NUM_WARPS - 1);
    else if (found)  last_q <= last_d;
  end

  logic older_exists;
  always_comb begin
    older_exists = 1'b0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (eligible[i] && (warp_age[i] > warp_age[issue_warp])) older_exists = 1'b1;
    end
  end

  assert_pick_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> eligible[issue_warp]);
  assert_idle_when_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible == '0) |-> !issue_valid);
  assert_oldest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !older_exists);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 8,
  parameter int AGE_W     = 3,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int THR_W    = warp_sched_pkg::thr_bits(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [THR_W-1:0]     launch_threads,
  output logic                 launch_accept,
  output logic [NUM_WARPS-1:0] launch_slots,
  input  logic [NUM_WARPS-1:0] warp_op_ready,
  input  logic [NUM_WARPS-1:0] warp_instr_valid,
  input  logic [NUM_WARPS-1:0] warp_done,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NUM_WARPS-1:0]            resident, eligible;
  logic [NUM_WARPS-1:0][AGE_W-1:0] warp_age;

  warp_slot_pool #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W), .THR_W(THR_W)) pool_i (
    .clk(clk), .rst_n(rst_n_s),
    .launch_valid(launch_valid), .launch_threads(launch_threads),
    .warp_done(warp_done),
    .launch_accept(launch_accept), .launch_slots(launch_slots),
    .resident(resident), .warp_age(warp_age)
  );

  assign eligible = resident & warp_op_ready & warp_instr_valid;

  warp_issue_pick #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W), .WID_W(WID_W)) pick_i (
    .clk(clk), .rst_n(rst_n_s),
    .eligible(eligible), .warp_age(warp_age),
    .issue_valid(issue_valid), .issue_warp(issue_warp)
  );

  assert_issue_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue_valid |-> (warp_op_ready[issue_warp] && warp_instr_valid[issue_warp]));
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n_s |-> (!issue_valid && !launch_accept));
endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int N = 8;

  logic       clk, rst_n;
  logic       launch_valid;
  logic [8:0] launch_threads;
  logic       launch_accept;
  logic [7:0] launch_slots, op_rdy, iv, done;
  logic       issue_valid;
  logic [2:0] issue_warp;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  warp_issue_sched #(.NUM_WARPS(N), .AGE_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_threads(launch_threads),
    .launch_accept(launch_accept), .launch_slots(launch_slots),
    .warp_op_ready(op_rdy), .warp_instr_valid(iv), .warp_done(done),
    .issue_valid(issue_valid), .issue_warp(issue_warp)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic cyc(input logic [7:0] r, input logic [7:0] v, input logic [7:0] d,
                     input logic lv, input int th);
    @(negedge clk);
    op_rdy = r; iv = v; done = d; launch_valid = lv; launch_threads = 9'(th);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_issue(input string req, input int exp_w);
    if (exp_w < 0) chk(req, int'(issue_valid), 0);
    else begin
      chk(req, int'(issue_valid), 1);
      chk(req, int'(issue_warp), exp_w);
    end
  endtask

  task automatic chk_launch(input string req, input int acc, input int mask);
    chk(req, int'(launch_accept), acc);
    if (acc != 0) chk(req, int'(launch_slots), mask);
  endtask

  task automatic t_reset;
    cyc(8'hFF, 8'hFF, 0, 1, 64);
    chk_launch("R1 accept in reset", 0, 0);
    chk_issue("R1 issue in reset", -1);
    rst_n = 1;
    cyc(8'hFF, 8'hFF, 0, 0, 0);
    chk_issue("R1 no resident warp", -1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic t_admit;
    cyc(0, 0, 0, 1, 128);  chk_launch("R2 128 threads", 1, 8'h0F);
    cyc(0, 0, 0, 1, 33);   chk_launch("R2 33 threads", 1, 8'h30);
    cyc(0, 0, 0, 1, 96);   chk_launch("R3 3 needed 2 free", 0, 0);
    cyc(0, 0, 0, 1, 0);    chk_launch("R4 zero threads", 0, 0);
    cyc(0, 0, 0, 1, 300);  chk_launch("R4 oversize", 0, 0);
    cyc(0, 0, 0, 1, 64);   chk_launch("R3 refusal left slots free", 1, 8'hC0);
    cyc(0, 0, 0, 1, 1);    chk_launch("R3 pool full", 0, 0);
  endtask

  task automatic t_issue;
    // ages: slots 0-3 = 2, 4-5 = 1, 6-7 = 0
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R7 oldest block first", 0);
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R10 back to back", 1);
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R8 rr", 2);
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R8 rr", 3);
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R8 rr wrap", 0);
    cyc(8'hF0, 8'hFF, 0, 0, 0); chk_issue("R7 next age", 4);
    cyc(8'hF0, 8'hFF, 0, 0, 0); chk_issue("R8 rr", 5);
    cyc(8'h54, 8'hFF, 0, 0, 0); chk_issue("R7 old beats rr", 2);
    cyc(8'h54, 8'hFB, 0, 0, 0); chk_issue("R5 instr invalid", 4);
    cyc(8'h00, 8'hFF, 0, 0, 0); chk_issue("R6 none ready", -1);
    cyc(8'hFF, 8'h00, 0, 0, 0); chk_issue("R5 none valid", -1);
  endtask

  task automatic t_retire;
    cyc(0, 0, 8'h0F, 0, 0);
    cyc(0, 0, 0, 1, 100);  chk_launch("R9 freed slots reused", 1, 8'h0F);
    // ages: 4-5 = 2, 6-7 = 1, 0-3 = 0; last issued 4
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R8 rr after last", 5);
    cyc(8'hFF, 8'hFF, 0, 0, 0); chk_issue("R8 rr", 4);
    cyc(8'h43, 8'hFF, 0, 0, 0); chk_issue("R7 older", 6);
    cyc(8'h03, 8'hFF, 0, 0, 0); chk_issue("R8 wrap to 0", 0);
    cyc(8'h03, 8'hFF, 0, 0, 0); chk_issue("R8 rr", 1);
    cyc(8'hFF, 8'hFF, 8'h30, 0, 0); chk_issue("R9 done same cycle", 4);
    cyc(8'h30, 8'hFF, 0, 0, 0); chk_issue("R9 freed not issued", -1);
  endtask

  initial begin
    rst_n = 0; op_rdy = 0; iv = 0; done = 0; launch_valid = 0; launch_threads = 0;
    t_reset();
    t_admit();
    t_issue();
    t_retire();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule